// File: doc/BRIEF.md
# Monitor and power-mode controller

This block holds the three host-written settings that decide what a battery-pack front end is doing at any moment: which cell measurement the monitor switches connect, whether that measurement reaches the analog output pin or the pin is tied to ground, and what the on-chip regulator delivers. The host does not write the power mode. The block works it out from those settings. A grounded output means power save. A routed output means usual operation. A regulator-off command, honoured only when no charger is attached, means power down.

Writes arrive already decoded. There is one strobe per register and a shared 3-bit data field. A separate pulse restores every setting to its reset value.

During power down the host has no supply, so writes are dropped. When a charger appears, the regulator restarts at its stored voltage, but the reported mode stays at power down. The mode leaves power down only when the host sends a valid regulator write, and it then returns to usual or power save according to the stored multiplexer setting. All outputs come straight from registers, so a change takes effect on the clock edge that samples it.

Top module: `mon_power_ctrl`

## Requirements
- R1: After reset, `powerMode` is 01 (power save), `switchEnable` is all zeros, `analogGround` is 1, `regVolt5` is 0 (3.3 V) and `regEnable` is 1.
- R2: In usual mode, `switchEnable` has exactly one bit set, at index `D2*CELLS + D1D0` of the last accepted monitor write. D2=0 selects the voltage of cell D1D0+1 and D2=1 selects the offset measurement of that cell. A monitor write whose D1D0 is CELLS or more is ignored.
- R3: Multiplexer code 001 selects usual mode (`powerMode` 00, `analogGround` 0). Codes 000, 010 and 011 select power save (`powerMode` 01, `analogGround` 1, `switchEnable` all zeros).
- R4: Multiplexer writes with D2=1 change nothing.
- R5: Regulator codes 000 and 011 give `regVolt5`=0, code 010 gives `regVolt5`=1, and codes with D2=1 change nothing.
- R6: Regulator code 001 with `chargerPresent` low enters power down: `powerMode` 10, `regEnable` 0, `switchEnable` all zeros, `analogGround` 1, and `regVolt5` keeps its value. While the regulator is off, monitor, multiplexer and regulator writes are dropped.
- R7: Regulator code 001 is ignored while `chargerPresent` is high.
- R8: In power down with the regulator off, a high `chargerPresent` raises `regEnable` on the next edge. `powerMode` stays 10 and the switches stay off, while monitor and multiplexer writes are stored again.
- R9: After the restart, a regulator write of 000, 010 or 011 sets the voltage and returns `powerMode` to 00 or 01 according to the stored multiplexer setting. Code 001 with no charger returns the block to regulator-off power down.
- R10: `softReset` restores all three settings and the reset mode from any state, and it overrides any write in the same cycle.
- R11: The monitor selection is kept through power save and becomes visible again when code 001 routes the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| chargerPresent | input | 1 | High while a charger is attached |
| softReset | input | 1 | One-cycle pulse that restores the settings |
| wrMon | input | 1 | Write strobe, monitor selection |
| wrMux | input | 1 | Write strobe, analog output multiplexer |
| wrReg | input | 1 | Write strobe, regulator setting |
| wrData | input | 3 | Shared write data, bit 2 is D2 |
| switchEnable | output | 2*CELLS | One-hot monitor switch-pair enables |
| analogGround | output | 1 | Analog output tied to ground |
| regVolt5 | output | 1 | Regulator voltage select, 1 = 5.0 V |
| regEnable | output | 1 | Regulator running |
| powerMode | output | 2 | 00 usual, 01 power save, 10 power down |

## Verification
The bench drives two copies of the block from the same stimulus, one built with CELLS=4 and one with CELLS=3. The four-cell copy covers every one of the eight monitor codes. The three-cell copy reaches the rejection of out-of-range cell codes and an offset index layout that is not a power of two. Directed sequences cover the charger-gated entry to power down, the restart and resume, and soft reset. A stretch of random traffic then checks both copies against a behavioural model on every clock.

// File: rtl/mon_power_pkg.sv
package mon_power_pkg;

  localparam int CMD_W = 3;

  localparam logic [CMD_W-1:0] MUX_ROUTE = 3'b001;
  localparam logic [CMD_W-1:0] REG_OFF   = 3'b001;
  localparam logic [CMD_W-1:0] REG_5V0   = 3'b010;

  typedef enum logic [1:0] {
    PS_ACTIVE = 2'd0,
    PS_DOWN   = 2'd1,
    PS_WAKE   = 2'd2
  } pwrState_t;

  typedef enum logic [1:0] {
    MODE_USUAL = 2'b00,
    MODE_SAVE  = 2'b01,
    MODE_DOWN  = 2'b10
  } pwrMode_t;

  typedef struct packed {
    logic clearRegs;
    logic loadMon;
    logic loadMux;
    logic loadVolt;
  } dpStrobe_t;

endpackage

// File: rtl/mon_power_ctrl_fsm.sv
module mon_power_ctrl_fsm
  import mon_power_pkg::*;
#(
  parameter int CELLS = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             softReset,
  input  logic             chargerPresent,
  input  logic             wrMon,
  input  logic             wrMux,
  input  logic             wrReg,
  input  logic [CMD_W-1:0] wrData,
  output dpStrobe_t        strobe,
  output pwrState_t        state
);

  pwrState_t stateNext;
  logic writesOpen;
  logic monCellOk;
  logic voltCode;
  logic powerDownReq;
  logic resumeReq;

  assign writesOpen   = (state != PS_DOWN);
  assign monCellOk    = int'(wrData[1:0]) < CELLS;
  assign voltCode     = !wrData[2] && (wrData != REG_OFF);
  assign powerDownReq = wrReg && writesOpen && (wrData == REG_OFF) && !chargerPresent;
  assign resumeReq    = wrReg && (state == PS_WAKE) && voltCode;

  always_comb begin
    strobe.clearRegs = softReset;
    strobe.loadMon   = !softReset && wrMon && writesOpen && monCellOk;
    strobe.loadMux   = !softReset && wrMux && writesOpen && !wrData[2];
    strobe.loadVolt  = !softReset && wrReg && writesOpen && voltCode;
  end

  always_comb begin
    stateNext = state;
    if (softReset) begin
      stateNext = PS_ACTIVE;
    end else begin
      unique case (state)
        PS_ACTIVE: if (powerDownReq) stateNext = PS_DOWN;
        PS_DOWN:   if (chargerPresent) stateNext = PS_WAKE;
        PS_WAKE: begin
          if (resumeReq) stateNext = PS_ACTIVE;
          else if (powerDownReq) stateNext = PS_DOWN;
        end
        default:   stateNext = PS_ACTIVE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= PS_ACTIVE;
    else       state <= stateNext;
  end

  // A regulator-off command with a charger attached leaves the block running.
  assert_charger_blocks_down_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == PS_ACTIVE && wrReg && wrData == REG_OFF && chargerPresent && !softReset)
      |=> state == PS_ACTIVE);

  // A charger seen during power down restarts the regulator.
  assert_charger_restarts_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == PS_DOWN && chargerPresent && !softReset) |=> state == PS_WAKE);

  // A 3.3 V regulator write after the restart resumes operation.
  assert_resume_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == PS_WAKE && wrReg && wrData == 3'b000 && !softReset) |=> state == PS_ACTIVE);

  assert_soft_reset_R10: assert property (@(posedge clk) disable iff (!rstN)
    softReset |=> state == PS_ACTIVE);

endmodule

// File: rtl/mon_power_datapath.sv
module mon_power_datapath
  import mon_power_pkg::*;
#(
  parameter int CELLS = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strobe,
  input  pwrState_t          pwrState,
  input  logic [CMD_W-1:0]   wrData,
  output logic [2*CELLS-1:0] switchEnable,
  output logic               analogGround,
  output logic               regVolt5,
  output logic               regEnable,
  output pwrMode_t           powerMode
);

  localparam int CELL_W = (CELLS > 1) ? $clog2(CELLS) : 1;
  localparam int PAIRS  = 2 * CELLS;

  logic [CELL_W-1:0] monCell;
  logic              monOffset;
  logic              muxRoute;
  logic              volt5;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      monCell   <= '0;
      monOffset <= 1'b0;
      muxRoute  <= 1'b0;
      volt5     <= 1'b0;
    end else if (strobe.clearRegs) begin
      monCell   <= '0;
      monOffset <= 1'b0;
      muxRoute  <= 1'b0;
      volt5     <= 1'b0;
    end else begin
      if (strobe.loadMon) begin
        monCell   <= wrData[CELL_W-1:0];
        monOffset <= wrData[2];
      end
      if (strobe.loadMux)  muxRoute <= (wrData == MUX_ROUTE);
      if (strobe.loadVolt) volt5    <= (wrData == REG_5V0);
    end
  end

  always_comb begin
    if (pwrState != PS_ACTIVE) powerMode = MODE_DOWN;
    else if (muxRoute)         powerMode = MODE_USUAL;
    else                       powerMode = MODE_SAVE;
  end

  assign analogGround = (powerMode != MODE_USUAL);
  assign regEnable    = (pwrState != PS_DOWN);
  assign regVolt5     = volt5;

  for (genvar g = 0; g < PAIRS; g++) begin : gPair
    localparam int  PAIR_CELL = g % CELLS;
    localparam bit  PAIR_OFFS = (g >= CELLS);
    assign switchEnable[g] = (powerMode == MODE_USUAL)
                          && (monOffset == PAIR_OFFS)
                          && (monCell == CELL_W'(PAIR_CELL));
  end

  assert_switch_onehot_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(switchEnable));

  // Routing write while running reaches the pin on the next edge.
  assert_route_opens_R3: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == PS_ACTIVE && strobe.loadMux && wrData == MUX_ROUTE)
      |=> (pwrState != PS_ACTIVE || !analogGround));

  assert_volt_select_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadVolt && wrData == REG_5V0) |=> regVolt5);

  // Settings stay frozen while the regulator is off.
  assert_down_holds_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == PS_DOWN && !strobe.clearRegs) |=> $stable({monCell, monOffset, muxRoute, volt5}));

endmodule

// File: rtl/mon_power_ctrl.sv
module mon_power_ctrl
  import mon_power_pkg::*;
#(
  parameter int CELLS = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               chargerPresent,
  input  logic               softReset,
  input  logic               wrMon,
  input  logic               wrMux,
  input  logic               wrReg,
  input  logic [2:0]         wrData,
  output logic [2*CELLS-1:0] switchEnable,
  output logic               analogGround,
  output logic               regVolt5,
  output logic               regEnable,
  output logic [1:0]         powerMode
);

  dpStrobe_t strobe;
  pwrState_t pwrState;
  pwrMode_t  modeInt;

  mon_power_ctrl_fsm #(.CELLS(CELLS)) u_fsm (
    .clk            (clk),
    .rstN           (rstN),
    .softReset      (softReset),
    .chargerPresent (chargerPresent),
    .wrMon          (wrMon),
    .wrMux          (wrMux),
    .wrReg          (wrReg),
    .wrData         (wrData),
    .strobe         (strobe),
    .state          (pwrState)
  );

  mon_power_datapath #(.CELLS(CELLS)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .pwrState     (pwrState),
    .wrData       (wrData),
    .switchEnable (switchEnable),
    .analogGround (analogGround),
    .regVolt5     (regVolt5),
    .regEnable    (regEnable),
    .powerMode    (modeInt)
  );

  assign powerMode = modeInt;

endmodule

// File: tb/mon_power_ctrl_bench.sv
module mon_power_ctrl_bench;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN = 1'b0;
  logic chargerPresent = 1'b0;
  logic softReset = 1'b0;
  logic wrMon = 1'b0, wrMux = 1'b0, wrReg = 1'b0;
  logic [2:0] wrData = 3'b000;

  logic [7:0] sw4;
  logic gnd4, v54, en4;
  logic [1:0] mode4;
  logic [5:0] sw3;
  logic gnd3, v53, en3;
  logic [1:0] mode3;

  mon_power_ctrl #(.CELLS(4)) u_mon_power_ctrl (
    .clk(clk), .rstN(rstN), .chargerPresent(chargerPresent), .softReset(softReset),
    .wrMon(wrMon), .wrMux(wrMux), .wrReg(wrReg), .wrData(wrData),
    .switchEnable(sw4), .analogGround(gnd4), .regVolt5(v54), .regEnable(en4),
    .powerMode(mode4));

  mon_power_ctrl #(.CELLS(3)) u_mon_power_ctrl_c3 (
    .clk(clk), .rstN(rstN), .chargerPresent(chargerPresent), .softReset(softReset),
    .wrMon(wrMon), .wrMux(wrMux), .wrReg(wrReg), .wrData(wrData),
    .switchEnable(sw3), .analogGround(gnd3), .regVolt5(v53), .regEnable(en3),
    .powerMode(mode3));

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  // Behavioural model: state 0 running, 1 regulator off, 2 restarted.
  int cellsOf[2] = '{4, 3};
  int mState[2], mMon[2], mRoute[2], mVolt[2];

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  always @(posedge clk or negedge rstN) begin
    for (int i = 0; i < 2; i++) begin
      if (!rstN || softReset) begin
        mState[i] = 0; mMon[i] = 0; mRoute[i] = 0; mVolt[i] = 0;
      end else begin
        int d, nxt;
        bit open, downReq, volt;
        d = int'(wrData);
        open = (mState[i] != 1);
        volt = (d < 4) && (d != 1);
        downReq = wrReg && open && (d == 1) && !chargerPresent;
        nxt = mState[i];
        if (mState[i] == 0 && downReq) nxt = 1;
        if (mState[i] == 1 && chargerPresent) nxt = 2;
        if (mState[i] == 2) begin
          if (wrReg && volt) nxt = 0;
          else if (downReq) nxt = 1;
        end
        if (wrMon && open && (d % 4) < cellsOf[i]) mMon[i] = d;
        if (wrMux && open && d < 4) mRoute[i] = (d == 1) ? 1 : 0;
        if (wrReg && open && volt) mVolt[i] = (d == 2) ? 1 : 0;
        mState[i] = nxt;
      end
    end
  end

  function automatic int expMode(input int i);
    if (mState[i] != 0) return 2;
    return (mRoute[i] != 0) ? 0 : 1;
  endfunction

  function automatic int expSw(input int i);
    if (expMode(i) != 0) return 0;
    return 1 << ((mMon[i] / 4) * cellsOf[i] + (mMon[i] % 4));
  endfunction

  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk("R2", "sw4 vs model", int'(sw4), expSw(0));
      chk("R3", "mode4 vs model", int'(mode4), expMode(0));
      chk("R3", "gnd4 vs model", int'(gnd4), (expMode(0) != 0) ? 1 : 0);
      chk("R5", "volt4 vs model", int'(v54), mVolt[0]);
      chk("R6", "en4 vs model", int'(en4), (mState[0] != 1) ? 1 : 0);
      chk("R2", "sw3 vs model", int'(sw3), expSw(1));
      chk("R3", "mode3 vs model", int'(mode3), expMode(1));
      chk("R3", "gnd3 vs model", int'(gnd3), (expMode(1) != 0) ? 1 : 0);
      chk("R5", "volt3 vs model", int'(v53), mVolt[1]);
      chk("R6", "en3 vs model", int'(en3), (mState[1] != 1) ? 1 : 0);
    end
  end

  task automatic pulse(input bit m, input bit x, input bit r, input logic [2:0] d);
    @(negedge clk);
    wrMon = m; wrMux = x; wrReg = r; wrData = d;
    @(negedge clk);
    wrMon = 1'b0; wrMux = 1'b0; wrReg = 1'b0;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "mode", int'(mode4), 1);
    chk("R1", "switches", int'(sw4), 0);
    chk("R1", "ground", int'(gnd4), 1);
    chk("R1", "volt5", int'(v54), 0);
    chk("R1", "regEnable", int'(en4), 1);

    // R3 route the monitor
    pulse(0, 1, 0, 3'b001);
    chk("R3", "mode after 001", int'(mode4), 0);
    chk("R3", "ground after 001", int'(gnd4), 0);
    chk("R3", "cell1 voltage pair", int'(sw4), 1);

    // R2 every monitor code on four cells
    for (int c = 0; c < 8; c++) begin
      pulse(1, 0, 0, 3'(c));
      chk("R2", "pair index 4-cell", int'(sw4), 1 << ((c / 4) * 4 + (c % 4)));
    end
    pulse(1, 0, 0, 3'b001);
    pulse(1, 0, 0, 3'b011);
    chk("R2", "out-of-range cell ignored 3-cell", int'(sw3), 6'b000010);
    chk("R2", "cell4 accepted 4-cell", int'(sw4), 8'b0000_1000);
    pulse(1, 0, 0, 3'b110);
    chk("R2", "offset cell3 on 3-cell", int'(sw3), 6'b100000);

    // R3 ground codes, R11 retention
    pulse(0, 1, 0, 3'b000);
    chk("R3", "save on 000", int'(mode4), 1);
    chk("R3", "switches off on 000", int'(sw4), 0);
    pulse(1, 0, 0, 3'b101);
    pulse(0, 1, 0, 3'b001);
    chk("R11", "selection back on route", int'(sw4), 1 << 5);
    pulse(0, 1, 0, 3'b010);
    chk("R3", "save on 010", int'(gnd4), 1);
    pulse(0, 1, 0, 3'b001);
    pulse(0, 1, 0, 3'b011);
    chk("R3", "save on 011", int'(mode4), 1);

    // R4 ignored multiplexer codes
    pulse(0, 1, 0, 3'b101);
    chk("R4", "101 leaves ground", int'(mode4), 1);
    pulse(0, 1, 0, 3'b001);
    pulse(0, 1, 0, 3'b100);
    chk("R4", "100 leaves route", int'(mode4), 0);

    // R5 regulator voltage
    pulse(0, 0, 1, 3'b010);
    chk("R5", "5V on 010", int'(v54), 1);
    pulse(0, 0, 1, 3'b111);
    chk("R5", "111 ignored", int'(v54), 1);
    pulse(0, 0, 1, 3'b011);
    chk("R5", "3.3V on 011", int'(v54), 0);
    pulse(0, 0, 1, 3'b010);
    pulse(0, 0, 1, 3'b000);
    chk("R5", "3.3V on 000", int'(v54), 0);
    pulse(0, 0, 1, 3'b010);

    // R7 charger blocks power down
    chargerPresent = 1'b1;
    pulse(0, 0, 1, 3'b001);
    chk("R7", "no power down with charger", int'(mode4), 0);
    chk("R7", "regulator still on", int'(en4), 1);

    // R6 power down and dropped writes
    chargerPresent = 1'b0;
    pulse(0, 0, 1, 3'b001);
    chk("R6", "mode down", int'(mode4), 2);
    chk("R6", "regulator off", int'(en4), 0);
    chk("R6", "switches off", int'(sw4), 0);
    chk("R6", "ground", int'(gnd4), 1);
    chk("R6", "voltage kept", int'(v54), 1);
    pulse(0, 1, 0, 3'b000);
    pulse(1, 0, 0, 3'b111);
    pulse(0, 0, 1, 3'b000);
    chk("R6", "writes dropped while off", int'(mode4), 2);
    chk("R6", "still off", int'(en4), 0);

    // R8 charger restart
    @(negedge clk); chargerPresent = 1'b1;
    @(negedge clk);
    chk("R8", "regulator restarted", int'(en4), 1);
    chk("R8", "mode still down", int'(mode4), 2);
    pulse(1, 0, 0, 3'b010);
    chk("R8", "switches still off", int'(sw4), 0);
    pulse(0, 0, 1, 3'b001);
    chk("R8", "off code ignored with charger", int'(en4), 1);

    // R9 resume
    pulse(0, 0, 1, 3'b000);
    chk("R9", "usual after resume", int'(mode4), 0);
    chk("R9", "voltage from resume", int'(v54), 0);
    chk("R9", "selection from restart", int'(sw4), 1 << 2);
    chargerPresent = 1'b0;
    pulse(0, 0, 1, 3'b001);
    @(negedge clk); chargerPresent = 1'b1;
    @(negedge clk); chargerPresent = 1'b0;
    pulse(0, 0, 1, 3'b001);
    chk("R9", "off again from restart", int'(en4), 0);

    // R10 soft reset beats a same-cycle write
    @(negedge clk);
    softReset = 1'b1; wrMux = 1'b1; wrData = 3'b001;
    @(negedge clk);
    softReset = 1'b0; wrMux = 1'b0;
    chk("R10", "mode save", int'(mode4), 1);
    chk("R10", "regulator on", int'(en4), 1);
    chk("R10", "volt 3.3", int'(v54), 0);
    pulse(0, 1, 0, 3'b001);
    chk("R10", "selection reset", int'(sw4), 1);

    // random traffic against the model
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      wrMon = ($urandom % 4) == 0;
      wrMux = ($urandom % 5) == 0;
      wrReg = ($urandom % 6) == 0;
      wrData = 3'($urandom);
      softReset = ($urandom % 50) == 0;
      if (($urandom % 12) == 0) chargerPresent = ~chargerPresent;
    end
    @(negedge clk);
    wrMon = 0; wrMux = 0; wrReg = 0; softReset = 0;
    @(negedge clk);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule